// File: doc/BRIEF.md
# Reduced-instruction boundary-scan test port

This block is the test access port of a memory device. It runs the sixteen-state test-port state machine from a slow test clock, a mode-select input, a serial data input and a synchronous active-low test reset. It produces a serial data output and an enable for that output. A three-bit instruction register picks which data register sits between the serial input and the serial output: a 32-bit identification register, a one-bit bypass register, or a boundary register of parameterised width. The boundary register takes a snapshot of the device's monitored pin values.

The instruction set is deliberately reduced. The boundary instructions only capture pin values. They never preload pins or drive them, and passing through Update-DR changes nothing that faces the pins. Two of the instructions also raise a control output that forces the device's data outputs to high impedance. Reserved codes behave as bypass.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The state machine reaches Test-Logic-Reset after five consecutive test clocks with mode-select high, from any state, and also on any clock edge where `trst_n` is low. In Test-Logic-Reset the active instruction becomes IDCODE (001).
- R2: An instruction is shifted in during Shift-IR, least significant bit first. The active instruction, and with it `out_hiz`, changes only on the clock edge that leaves Update-IR.
- R3: Capture-IR loads the fixed pattern 001, so an IR scan first returns 1, 0, 0 on `tdo`.
- R4: With IDCODE (001) active, a DR scan returns the 32-bit `ID_VALUE`, least significant bit first, followed by the serial input delayed by 32 clocks.
- R5: BYPASS (111) and the reserved codes 011, 101 and 110 select a one-bit register. This register captures 0 in Capture-DR, so a DR scan returns 0 followed by the serial input delayed by one clock.
- R6: The boundary codes EXTEST (000), SAMPLE-Z (010) and SAMPLE (100) capture `pins_i` in Capture-DR. A DR scan then returns bit 0 first, over `PIN_W` bits, followed by the serial input delayed by `PIN_W` clocks.
- R7: `out_hiz` is high exactly while the active instruction is 000 or 010.
- R8: Passing through Update-DR has no effect. `out_hiz` keeps its value, and data shifted in never appears at the pins. The next capture again reloads the live `pins_i` values.
- R9: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only while the state is Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pins_i | input | PIN_W | Monitored device pin values |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for `tdo` |
| out_hiz | output | 1 | Forces the device data outputs to high impedance |

## Verification
The hardest situations to reach from the ports are an instruction that has been shifted in but not yet updated, and an abandoned scan recovered by mode-select alone. The stimulus stops an IR scan in Exit1-IR and checks that `out_hiz` still follows the old instruction. It also breaks off a DR scan midway with five high mode-select clocks, then checks that an identification scan follows. A further sequence changes the pins after a boundary scan that passed through Update-DR, which shows that the shifted-in data was discarded.

// File: rtl/scan_tap_pkg.sv
// scan_tap_pkg: shared state encoding, instruction codes and data-register
// selection for the reduced-instruction test port.
package scan_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {SEL_BND, SEL_ID, SEL_BYP} dr_sel_t;

    // Map an instruction code to the data register it places in the chain.
    function automatic dr_sel_t dr_select(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return SEL_BND;
            OP_IDCODE:                        return SEL_ID;
            default:                          return SEL_BYP;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// tap_fsm: sixteen-state test-port controller.
// Assumes tms is stable around the rising edge of tck; trst_n acts synchronously.
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state_q
);

    tap_state_t state_d;

    // Next state from current state and mode select.
    always_comb begin
        case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

endmodule

// File: rtl/tap_ir.sv
// tap_ir: instruction shift stage and active-instruction latch.
// Assumes the controller state comes from tap_fsm in the same clock domain.
module tap_ir
    import scan_tap_pkg::*;
#(
    parameter int              W       = IR_W,
    parameter logic [W-1:0]    CAP_PAT = IR_CAPTURE,
    parameter logic [W-1:0]    RST_OP  = OP_IDCODE
) (
    input  logic         tck,
    input  logic         trst_n,
    input  tap_state_t   state_q,
    input  logic         tdi,
    output logic [W-1:0] op_q,
    output logic         ir_lsb
);

    logic [W-1:0] sh_q;

    // Shift stage: load the capture pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                  sh_q <= CAP_PAT;
        else if (state_q == ST_CAP_IR) sh_q <= CAP_PAT;
        else if (state_q == ST_SH_IR)  sh_q <= {tdi, sh_q[W-1:1]};
    end

    // Active instruction: IDCODE in reset, new code only when leaving Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state_q == ST_RESET) op_q <= RST_OP;
        else if (state_q == ST_UPD_IR)      op_q <= sh_q;
    end

    assign ir_lsb = sh_q[0];

endmodule

// File: rtl/tap_dr.sv
// tap_dr: identification, bypass and capture-only boundary registers.
// Assumes pins_i is stable around the Capture-DR edge; Update-DR is ignored.
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          PIN_W    = 16,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_3E27
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state_q,
    input  logic [IR_W-1:0]  op_q,
    input  logic             tdi,
    input  logic [PIN_W-1:0] pins_i,
    output logic             dr_lsb
);

    localparam int ID_W = 32;

    dr_sel_t          sel;
    logic             cap, shf;
    logic [ID_W-1:0]  id_q;
    logic             byp_q;
    logic [PIN_W-1:0] bnd_q;

    assign sel = dr_select(op_q);
    assign cap = (state_q == ST_CAP_DR);
    assign shf = (state_q == ST_SH_DR);

    // Identification register: reload the fixed value, then shift out.
    always_ff @(posedge tck) begin
        if (!trst_n)                      id_q <= ID_VALUE;
        else if (cap && sel == SEL_ID)    id_q <= ID_VALUE;
        else if (shf && sel == SEL_ID)    id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Bypass bit: captures zero, then passes tdi one clock late.
    always_ff @(posedge tck) begin
        if (!trst_n)                      byp_q <= 1'b0;
        else if (cap && sel == SEL_BYP)   byp_q <= 1'b0;
        else if (shf && sel == SEL_BYP)   byp_q <= tdi;
    end

    // Boundary cells: each snapshots its pin or takes its upper neighbour.
    for (genvar i = 0; i < PIN_W; i++) begin : g_cell
        logic nxt;
        if (i == PIN_W - 1) begin : g_top
            assign nxt = tdi;
        end else begin : g_mid
            assign nxt = bnd_q[i+1];
        end
        // One boundary cell; no update stage exists.
        always_ff @(posedge tck) begin
            if (!trst_n)                      bnd_q[i] <= 1'b0;
            else if (cap && sel == SEL_BND)   bnd_q[i] <= pins_i[i];
            else if (shf && sel == SEL_BND)   bnd_q[i] <= nxt;
        end
    end

    // Serial output of the selected register.
    always_comb begin
        case (sel)
            SEL_BND: dr_lsb = bnd_q[0];
            SEL_ID:  dr_lsb = id_q[0];
            default: dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_tap_ctrl.sv
// scan_tap_ctrl: reduced-instruction test port top level.
// Assumes a single test clock; tdo is retimed to the falling edge.
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int          PIN_W    = 16,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_3E27
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [PIN_W-1:0] pins_i,
    output logic             tdo,
    output logic             tdo_en,
    output logic             out_hiz
);

    tap_state_t      state_q;
    logic [IR_W-1:0] op_q;
    logic            ir_lsb, dr_lsb;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q)
    );

    tap_ir #(.W(IR_W), .CAP_PAT(IR_CAPTURE), .RST_OP(OP_IDCODE)) u_ir (
        .tck(tck), .trst_n(trst_n), .state_q(state_q), .tdi(tdi),
        .op_q(op_q), .ir_lsb(ir_lsb)
    );

    tap_dr #(.PIN_W(PIN_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .trst_n(trst_n), .state_q(state_q), .op_q(op_q),
        .tdi(tdi), .pins_i(pins_i), .dr_lsb(dr_lsb)
    );

    // Output-disable request for the two instructions that float the outputs.
    assign out_hiz = (op_q == OP_EXTEST) || (op_q == OP_SAMPLEZ);

    // Falling-edge retiming of serial output and its enable.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
            tdo    <= (state_q == ST_SH_IR) ? ir_lsb :
                      (state_q == ST_SH_DR) ? dr_lsb : 1'b0;
        end
    end

endmodule

// File: rtl/scan_tap_chk.sv
// scan_tap_chk: temporal checks on the test port, bound into scan_tap_ctrl.
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input tap_state_t      state_q,
    input logic [IR_W-1:0] op_q,
    input logic            tdo,
    input logic            tdo_en,
    input logic            out_hiz
);

    p_reset_idcode_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET) |=> (op_q == OP_IDCODE));

    p_op_hold_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q != ST_UPD_IR && state_q != ST_RESET) |=> $stable(op_q));

    p_hiz_map_r7: assert property (@(posedge tck) disable iff (!trst_n)
        out_hiz |-> (op_q == OP_EXTEST || op_q == OP_SAMPLEZ));

    p_upd_dr_quiet_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_UPD_DR) |=> $stable(out_hiz));

    p_en_in_shift_r9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_q == ST_SH_IR || state_q == ST_SH_DR));

    p_tdo_quiet_r9: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo);

endmodule

bind scan_tap_ctrl scan_tap_chk u_chk (
    .tck(tck), .trst_n(trst_n), .state_q(state_q), .op_q(op_q),
    .tdo(tdo), .tdo_en(tdo_en), .out_hiz(out_hiz)
);

// File: tb/scan_tap_ctrl_bench.sv
`timescale 1ns/1ps
module scan_tap_ctrl_bench;

    localparam int          PW   = 16;
    localparam logic [31:0] IDV  = 32'h1A5C_3E27;
    localparam int          SCAN = 48;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [PW-1:0] pins = 16'hC35A;
    logic          tdo, tdo_en, out_hiz;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    scan_tap_ctrl #(.PIN_W(PW), .ID_VALUE(IDV)) u_scan_tap_ctrl (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pins_i(pins),
        .tdo(tdo), .tdo_en(tdo_en), .out_hiz(out_hiz)
    );

    always #2.5 tck = ~tck;

    // Table: {code, kind (0 boundary, 1 id, 2 bypass), expected out_hiz}
    localparam logic [5:0] VEC [8] = '{
        {3'b000, 2'd0, 1'b1}, {3'b001, 2'd1, 1'b0},
        {3'b010, 2'd0, 1'b1}, {3'b011, 2'd2, 1'b0},
        {3'b100, 2'd0, 1'b0}, {3'b101, 2'd2, 1'b0},
        {3'b110, 2'd2, 1'b0}, {3'b111, 2'd2, 1'b0}
    };

    localparam logic [SCAN-1:0] PAT = 48'h9D3B_66E1_F04A;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One test clock: drive inputs, sample tdo before the rising edge.
    task automatic step(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        #3;
        o = tdo;
        @(posedge tck);
        #1;
    endtask

    task automatic to_idle_by_tms();
        logic o;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic ir_scan(input logic [2:0] code, output logic [2:0] got);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], o);
            got[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic dr_scan(input logic [SCAN-1:0] pat, output logic [SCAN-1:0] got);
        logic o;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < SCAN; i++) begin
            step(i == SCAN - 1, pat[i], o);
            got[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    function automatic logic [SCAN-1:0] expect_scan(input int len, input logic [31:0] cap,
                                                    input logic [SCAN-1:0] pat);
        logic [SCAN-1:0] r;
        for (int i = 0; i < SCAN; i++) r[i] = (i < len) ? cap[i] : pat[i - len];
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0]      irg;
        logic [SCAN-1:0] g;
        logic            o;
        repeat (3) @(posedge tck);
        #1;
        // R9: reset state with outputs quiet
        chk("R9 reset tdo_en", {63'd0, tdo_en}, 64'd0);
        chk("R7 reset out_hiz", {63'd0, out_hiz}, 64'd0);
        trst_n = 1'b1;
        step(0, 0, o);

        // R1/R4: IDCODE active after reset
        dr_scan(PAT, g);
        chk("R4 idcode after reset", {16'd0, g}, {16'd0, expect_scan(32, IDV, PAT)});

        // Table walk over all eight codes (R3, R5, R6, R7)
        for (int k = 0; k < 8; k++) begin
            logic [2:0] code;
            logic [1:0] kind;
            int         len;
            logic [31:0] cap;
            code = VEC[k][5:3];
            kind = VEC[k][2:1];
            ir_scan(code, irg);
            chk($sformatf("R3 capture pattern code %0d", code), {61'd0, irg}, 64'd1);
            chk($sformatf("R7 out_hiz code %0d", code), {63'd0, out_hiz}, {63'd0, VEC[k][0]});
            case (kind)
                2'd0:    begin len = PW; cap = {16'd0, pins}; end
                2'd1:    begin len = 32; cap = IDV;           end
                default: begin len = 1;  cap = 32'd0;         end
            endcase
            dr_scan(PAT, g);
            chk($sformatf("%s scan code %0d", kind == 0 ? "R6" : kind == 1 ? "R4" : "R5", code),
                {16'd0, g}, {16'd0, expect_scan(len, cap, PAT)});
        end

        // R8: Update-DR under SAMPLE leaves pins side alone; next capture is live
        ir_scan(3'b010, irg);
        dr_scan(PAT, g);
        chk("R8 out_hiz held through update", {63'd0, out_hiz}, 64'd1);
        ir_scan(3'b100, irg);
        pins = 16'h0F96;
        dr_scan(PAT, g);
        pins = 16'h7711;
        dr_scan(PAT, g);
        chk("R8 recapture live pins", {16'd0, g}, {16'd0, expect_scan(PW, 32'h7711, PAT)});

        // R2: shifted code not active until Update-IR
        ir_scan(3'b000, irg);
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        step(0, 1, o); step(0, 1, o); step(1, 1, o);
        chk("R2 held in Exit1-IR", {63'd0, out_hiz}, 64'd1);
        step(1, 0, o);
        chk("R2 held in Update-IR", {63'd0, out_hiz}, 64'd1);
        step(0, 0, o);
        chk("R2 applied after Update-IR", {63'd0, out_hiz}, 64'd0);

        // R9: enable rises on the falling edge after entering Shift-DR
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        chk("R9 enable not before falling edge", {63'd0, tdo_en}, 64'd0);
        #2;
        chk("R9 enable after falling edge", {63'd0, tdo_en}, 64'd1);
        #2;
        // R1: abandon scan mid-way with five high tms clocks
        to_idle_by_tms();
        chk("R1 tms reset clears hiz", {63'd0, out_hiz}, 64'd0);
        chk("R9 enable off in idle", {63'd0, tdo_en}, 64'd0);
        dr_scan(PAT, g);
        chk("R1 idcode after tms reset", {16'd0, g}, {16'd0, expect_scan(32, IDV, PAT)});

        // R1: synchronous trst_n during a boundary instruction
        ir_scan(3'b010, irg);
        trst_n = 1'b0;
        step(0, 0, o);
        trst_n = 1'b1;
        step(0, 0, o);
        chk("R1 trst clears hiz", {63'd0, out_hiz}, 64'd0);
        dr_scan(PAT, g);
        chk("R1 idcode after trst", {16'd0, g}, {16'd0, expect_scan(32, IDV, PAT)});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule